// File: doc/BRIEF.md
# Fall-Through Shift-Chain FIFO with Strobe Handshake

This block is a first-in first-out buffer built as a chain of single-word storage cells rather than a RAM with read and write pointers. Each cell carries its own occupancy flag. A word written at the input end moves one cell per clock toward the output end whenever the next cell is empty. Words therefore pack against the output stage, and free slots drift back toward the input. With the default parameters the buffer holds 64 words of 4 bits.

Both sides use a level strobe handshake that is sampled on the system clock. A writer waits for `in_ready`, presents a word and raises `push_strobe`. The word is captured on the clock where the rise is seen, and it stays parked in the input cell until the strobe is dropped. A reader waits for `out_ready` and raises `pop_strobe`. The output word stays steady while the strobe is high. When the strobe falls, the next packed word steps into the output stage on that same clock. Reset is synchronous and active low.

Top module: `fallthru_fifo`

## Requirements
- R1: When `clear_n` is sampled low on a clock edge, the buffer empties. After that edge `in_ready` is 1 and `out_ready` is 0.
- R2: If `in_ready` is 1 on the clock edge where `push_strobe` is first seen high, `din` is captured and `in_ready` is 0 after that edge.
- R3: For as long as `push_strobe` stays high after a capture, the word stays in the input cell and `in_ready` stays 0.
- R4: On the edge where `push_strobe` is first seen low, the word leaves the input cell if the next cell is empty, and `in_ready` is 1 after that edge. If the buffer holds 64 words, `in_ready` stays 0.
- R5: The buffer accepts exactly DEPTH (64) words. A rise of `push_strobe` while `in_ready` is 0 is ignored and stores nothing.
- R6: A word advances one cell per clock. In an empty buffer, `out_ready` rises exactly DEPTH-2 (62) clocks after the edge that releases the word from the input cell.
- R7: On the edge where `pop_strobe` is first seen high while `out_ready` is 1, `out_ready` drops to 0. `dout` holds its value while `pop_strobe` stays high.
- R8: On the edge where `pop_strobe` is first seen low, the word in the cell next to the output stage, if that cell is occupied, enters the output stage. `out_ready` is then 1 after that same edge.
- R9: When the last word has been taken, `out_ready` stays 0 and `dout` keeps the last word it showed.
- R10: Words leave in the order they were captured, with none lost and none duplicated, under any interleaving of the two strobes.
- R11: A rise of `pop_strobe` while `out_ready` is 0 is ignored and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Synchronous reset, active low; empties the buffer |
| din | input | WIDTH | Word to be written |
| push_strobe | input | 1 | Write strobe; rise captures, fall releases |
| in_ready | output | 1 | Input cell is empty and can accept a word |
| pop_strobe | input | 1 | Read strobe; rise takes, fall advances |
| dout | output | WIDTH | Word in the output stage |
| out_ready | output | 1 | Output stage holds a word that has not been taken |

## Verification
A corrupted occupancy flag in the middle of the chain shows up at the ports as a missing word, a repeated word or a word out of order. It becomes visible when that word reaches `dout`, which can be as late as DEPTH clocks after the fault. The exact 62-clock fall-through count catches a cell that stalls or skips. A wrong input-hold or output-taken state shows up within one clock, because `in_ready` or `out_ready` is then wrong at the strobe edges. The filled-buffer pops check that the output stage refills on the same edge as the strobe fall.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

  // Decoded view of one sampled strobe
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_ev_t;

endpackage

// File: rtl/ftf_strobe_edge.sv
module ftf_strobe_edge
  import ftf_pkg::*;
(
  input  logic       clk,
  input  logic       clear_n,
  input  logic       strobe,
  output strobe_ev_t ev
);

  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!clear_n) strobe_q <= 1'b0;
    else          strobe_q <= strobe;
  end

  always_comb begin
    ev.level = strobe;
    ev.rise  = strobe & ~strobe_q;
    ev.fall  = ~strobe & strobe_q;
  end

endmodule

// File: rtl/ftf_stage.sv
module ftf_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             drain,
  output logic             full,
  output logic [WIDTH-1:0] word
);

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      full <= (full & ~drain) | load;
      if (load) word <= load_word;
    end
  end

  // R10: a word is never written over an occupied cell that is not emptying
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!clear_n)
    (full && load) |-> drain);

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import ftf_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] din,
  input  logic             push_strobe,
  output logic             in_ready,
  input  logic             pop_strobe,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready
);

  localparam int LAST = DEPTH - 1;

  strobe_ev_t push_ev, pop_ev;

  logic [DEPTH-1:0] full, load, drain, room;
  logic [DEPTH-2:0] move;
  logic [WIDTH-1:0] cell_q [DEPTH];
  logic [WIDTH-1:0] cell_d [DEPTH];

  logic in_hold;   // input cell parked while push strobe is high
  logic taken;     // output word claimed, waiting for strobe fall
  logic free0;
  logic pop_release;

  ftf_strobe_edge u_push_edge (.clk(clk), .clear_n(clear_n), .strobe(push_strobe), .ev(push_ev));
  ftf_strobe_edge u_pop_edge  (.clk(clk), .clear_n(clear_n), .strobe(pop_strobe),  .ev(pop_ev));

  assign free0       = ~in_hold | push_ev.fall;
  assign pop_release = taken & pop_ev.fall;

  assign load[0]   = push_ev.rise & ~full[0];
  assign cell_d[0] = din;
  assign drain[LAST] = pop_release;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_room
      if (i == LAST) begin : g_out
        assign room[i] = ~full[i] | pop_release;
      end else begin : g_mid
        assign room[i] = ~full[i];
      end
    end

    for (i = 0; i < DEPTH - 1; i++) begin : g_link
      if (i == 0) begin : g_head
        assign move[i] = full[i] & room[i+1] & free0;
      end else begin : g_body
        assign move[i] = full[i] & room[i+1];
      end
      assign drain[i]    = move[i];
      assign load[i+1]   = move[i];
      assign cell_d[i+1] = cell_q[i];
    end

    for (i = 0; i < DEPTH; i++) begin : g_cell
      ftf_stage #(.WIDTH(WIDTH)) u_stage (
        .clk      (clk),
        .clear_n  (clear_n),
        .load     (load[i]),
        .load_word(cell_d[i]),
        .drain    (drain[i]),
        .full     (full[i]),
        .word     (cell_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      in_hold <= 1'b0;
      taken   <= 1'b0;
    end else begin
      if (load[0])           in_hold <= 1'b1;
      else if (push_ev.fall) in_hold <= 1'b0;

      if (pop_ev.rise && out_ready) taken <= 1'b1;
      else if (pop_release)         taken <= 1'b0;
    end
  end

  assign in_ready  = ~full[0];
  assign out_ready = full[LAST] & ~taken;
  assign dout      = cell_q[LAST];

  // R1: reset leaves the buffer empty
  a_r1_reset_state: assert property (@(posedge clk)
    !clear_n |=> (in_ready && !out_ready));

  // R2: an accepted push rise closes the input
  a_r2_capture: assert property (@(posedge clk) disable iff (!clear_n)
    (push_ev.rise && in_ready) |=> !in_ready);

  // R3: the parked word keeps the input closed while the strobe is high
  a_r3_hold: assert property (@(posedge clk) disable iff (!clear_n)
    (in_hold && push_strobe) |=> !in_ready);

  // R7: the claimed output word is held steady
  a_r7_stable_out: assert property (@(posedge clk) disable iff (!clear_n)
    (taken && pop_strobe) |=> ($stable(dout) && !out_ready));

  // R9: an empty output stage with nothing arriving keeps its last word
  a_r9_empty_keep: assert property (@(posedge clk) disable iff (!clear_n)
    (!full[LAST] && !load[LAST]) |=> ($stable(dout) && !out_ready));

endmodule

// File: tb/fallthru_fifo_test.sv
module fallthru_fifo_test;

  localparam int W = 4;
  localparam int D = 64;

  logic         clk = 1'b0;
  logic         clear_n;
  logic [W-1:0] din;
  logic         push_strobe;
  logic         in_ready;
  logic         pop_strobe;
  logic [W-1:0] dout;
  logic         out_ready;

  int n_checks = 0;
  int n_fail   = 0;
  int q[$];

  fallthru_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .clear_n(clear_n), .din(din), .push_strobe(push_strobe),
    .in_ready(in_ready), .pop_strobe(pop_strobe), .dout(dout), .out_ready(out_ready)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_in_ready();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic wait_out_ready();
    while (!out_ready) @(negedge clk);
  endtask

  // Push one word; returns at a negedge with the strobe just dropped
  task automatic push_word(input logic [W-1:0] d, input int hold);
    wait_in_ready();
    din = d;
    push_strobe = 1'b1;
    q.push_back(int'(d));
    @(negedge clk);
    check(in_ready == 1'b0, "R2 capture closes input", int'(in_ready), 0);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R3 input held", int'(in_ready), 0);
    end
    push_strobe = 1'b0;
  endtask

  // Pop one word against the reference queue
  task automatic pop_word(input int hold, input bit refill_expected);
    logic [W-1:0] seen;
    int exp;
    wait_out_ready();
    exp = (q.size() > 0) ? q.pop_front() : -1;
    check(int'(dout) == exp, "R10 order", int'(dout), exp);
    seen = dout;
    pop_strobe = 1'b1;
    @(negedge clk);
    check(out_ready == 1'b0, "R7 claim drops out_ready", int'(out_ready), 0);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(dout == seen, "R7 dout stable", int'(dout), int'(seen));
    end
    pop_strobe = 1'b0;
    @(negedge clk);
    if (refill_expected)
      check(out_ready == 1'b1, "R8 same-edge refill", int'(out_ready), 1);
  endtask

  task automatic t_reset();
    clear_n = 1'b0;
    push_strobe = 1'b0;
    pop_strobe = 1'b0;
    din = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_ready == 1'b0, "R1 out_ready after reset", int'(out_ready), 0);
    clear_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single_latency();
    push_word(4'hA, 3);
    @(negedge clk);  // release edge has passed
    check(in_ready == 1'b1, "R4 release reopens input", int'(in_ready), 1);
    repeat (61) @(negedge clk);
    check(out_ready == 1'b0, "R6 not yet at output", int'(out_ready), 0);
    @(negedge clk);
    check(out_ready == 1'b1, "R6 arrives after 62 clocks", int'(out_ready), 1);
    check(dout == 4'hA, "R6 word value", int'(dout), 10);
    pop_word(3, 1'b0);
    repeat (5) @(negedge clk);
    check(out_ready == 1'b0, "R9 empty stays low", int'(out_ready), 0);
    check(dout == 4'hA, "R9 dout keeps last", int'(dout), 10);
  endtask

  task automatic t_fill_full();
    for (int k = 0; k < D - 1; k++) push_word(W'(k * 7 + 3), 1);
    repeat (70) @(negedge clk);
    push_word(4'h5, 4);
    @(negedge clk);
    check(in_ready == 1'b0, "R4 full keeps input closed", int'(in_ready), 0);
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R5 still full", int'(in_ready), 0);
    din = 4'hF;
    push_strobe = 1'b1;
    @(negedge clk);
    push_strobe = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R5 extra push ignored", int'(in_ready), 0);
    for (int k = 0; k < D; k++) pop_word(1, k < D - 1);
    check(out_ready == 1'b0, "R9 drained after 64", int'(out_ready), 0);
    check(dout == 4'h5, "R9 last word kept", int'(dout), 5);
    repeat (D + 4) @(negedge clk);
    check(out_ready == 1'b0, "R5 no 65th word", int'(out_ready), 0);
    check(in_ready == 1'b1, "R4 input reopens when drained", int'(in_ready), 1);
  endtask

  task automatic t_pop_ignored();
    pop_strobe = 1'b1;
    @(negedge clk);
    pop_strobe = 1'b0;
    @(negedge clk);
    push_word(4'hB, 0);
    repeat (D + 2) @(negedge clk);
    check(out_ready == 1'b1, "R11 word present after idle pop", int'(out_ready), 1);
    pop_word(0, 1'b0);
    repeat (D + 2) @(negedge clk);
    check(out_ready == 1'b0, "R11 nothing extra", int'(out_ready), 0);
  endtask

  task automatic t_random();
    int exp;
    for (int c = 0; c < 4000; c++) begin
      if (!push_strobe && in_ready && ($urandom % 3 == 0)) begin
        din = W'($urandom);
        push_strobe = 1'b1;
        q.push_back(int'(din));
      end else if (push_strobe && ($urandom % 2 == 0)) begin
        push_strobe = 1'b0;
      end
      if (!pop_strobe && out_ready && ($urandom % 3 == 0)) begin
        exp = (q.size() > 0) ? q.pop_front() : -1;
        check(int'(dout) == exp, "R10 random order", int'(dout), exp);
        pop_strobe = 1'b1;
      end else if (pop_strobe && ($urandom % 2 == 0)) begin
        pop_strobe = 1'b0;
      end
      @(negedge clk);
    end
    push_strobe = 1'b0;
    pop_strobe = 1'b0;
    @(negedge clk);
    while (q.size() > 0) pop_word(0, 1'b0);
    repeat (D + 2) @(negedge clk);
    check(out_ready == 1'b0, "R10 no duplicate after drain", int'(out_ready), 0);
  endtask

  initial begin
    t_reset();
    t_single_latency();
    t_fill_full();
    t_pop_ignored();
    t_random();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule